// File: doc/BRIEF.md
# Per-Core Timer Event Interrupt Steering

This block gathers the timer event lines of four processor cores and turns them into one IRQ and one FIQ request for each core. Every core has four level-sensitive timer events: secure physical, non-secure physical, hypervisor physical and virtual. Every core also has one 8-bit control register. For each event the register holds two enables. One places the event on the core's IRQ line. The other places it on the core's FIQ line.

The FIQ enable takes priority over the IRQ enable. When an event's FIQ enable is set, that event reaches only the FIQ line, whatever its IRQ enable holds. Software writes and reads the four control registers over a simple 32-bit register bus. Each core's outputs are registered, so they follow the event and enable levels one clock later and latch nothing in between. The asynchronous active-low reset is released synchronously inside the block.

Top module: `tsteer_top`

## Requirements
- R1: After reset every control register reads zero, and all IRQ and FIQ outputs stay low even when every event input is high.
- R2: Control bits 0, 1, 2 and 3 are the IRQ enables for event indices 0 (secure physical), 1 (non-secure physical), 2 (hypervisor physical) and 3 (virtual). Event e of core c arrives on evt_i bit 4*c+e.
- R3: Control bits 4 to 7 are the FIQ enables for event indices 0 to 3, in that order. A core's FIQ output is the OR over its events of (event AND FIQ enable).
- R4: A core's IRQ output is the OR over its events of (event AND IRQ enable AND NOT FIQ enable). A set FIQ enable makes the IRQ enable of the same event ignored.
- R5: The control registers of cores 0, 1, 2 and 3 sit at byte offsets 0x40, 0x44, 0x48 and 0x4C. A write to any other offset changes no register.
- R6: Register bits 31:8 ignore writes and read as zero.
- R7: A read (bus_valid_i high, bus_write_i low) places the addressed register on bus_rdata_o after the next clock edge. The read data holds until the next read.
- R8: The outputs are registered and level-following. A change on an event or enable shows at the outputs one clock edge later and not before, and an output falls one edge after its cause goes away.
- R9: The steering of each core depends only on that core's register and events. Events of other cores never reach its outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| evt_i | input | 16 | Timer event levels, bit 4*core+event |
| irq_o | output | 4 | IRQ request per core |
| fiq_o | output | 4 | FIQ request per core |

## Verification
Assertions check the following on every cycle:
- a register holds its value on any cycle that does not write its own offset;
- a core whose events are all low, or whose register is zero, raises nothing on the next cycle;
- a core with all four FIQ enables set never raises IRQ;
- read data carries zeros in its reserved bits.

The exact bit-to-event mapping and the override for mixed enable patterns can only be shown by the bench, which sweeps all 256 register values against all 16 event patterns on each core. The bench also covers the one-cycle timing, writes to neighbouring offsets, and isolation between cores.

// File: rtl/tsteer_pkg.sv
package tsteer_pkg;
  localparam int NCORE   = 4;
  localparam int NEVT    = 4;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int CTRL_W  = 2 * NEVT;
  localparam logic [ADDR_W-1:0] BASE_OFS = 8'h40;
  localparam int SLOT_STRIDE = DATA_W / 8;

  typedef logic [CTRL_W-1:0] ctrl_t;
endpackage

// File: rtl/tsteer_regbank.sv
module tsteer_regbank #(
  parameter int NCORE  = tsteer_pkg::NCORE,
  parameter int NEVT   = tsteer_pkg::NEVT,
  parameter int ADDR_W = tsteer_pkg::ADDR_W,
  parameter int DATA_W = tsteer_pkg::DATA_W,
  parameter logic [ADDR_W-1:0] BASE = tsteer_pkg::BASE_OFS,
  parameter int STRIDE = tsteer_pkg::SLOT_STRIDE
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_valid,
  input  logic                      bus_write,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic [NCORE*2*NEVT-1:0]   ctrl_flat
);
  localparam int CW = 2 * NEVT;

  logic [CW-1:0]     ctrl_q [NCORE];
  logic [NCORE-1:0]  slot_hit;
  logic [DATA_W-1:0] rd_sel;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              rd_en;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[DATA_W-1:CW];

  for (genvar c = 0; c < NCORE; c++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT = BASE + ADDR_W'(c * STRIDE);
    logic          wr_en;
    logic [CW-1:0] ctrl_d;

    assign slot_hit[c] = (bus_addr == SLOT);
    assign wr_en       = bus_valid && bus_write && slot_hit[c];

    always_comb begin
      ctrl_d = ctrl_q[c];
      if (wr_en) ctrl_d = bus_wdata[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_q[c] <= '0;
      else if (wr_en) ctrl_q[c] <= ctrl_d;
    end

    assign ctrl_flat[c*CW +: CW] = ctrl_q[c];

    // R5: a register moves only on a write to its own offset
    p_hold_unless_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && bus_write && bus_addr == SLOT) |=> $stable(ctrl_q[c]));
  end

  always_comb begin
    rd_sel = '0;
    for (int c = 0; c < NCORE; c++) begin
      if (slot_hit[c]) rd_sel[CW-1:0] = ctrl_q[c];
    end
  end

  assign rd_en = bus_valid && !bus_write;

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = rd_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  // R6: reserved read bits are zero
  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:CW] == '0);

  // R7: read data holds between reads
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(bus_rdata));
endmodule

// File: rtl/tsteer_core_mux.sv
module tsteer_core_mux #(
  parameter int NEVT = tsteer_pkg::NEVT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] evt,
  input  logic [NEVT-1:0] irq_en,
  input  logic [NEVT-1:0] fiq_en,
  output logic            irq,
  output logic            fiq
);
  logic [NEVT-1:0] irq_route, fiq_route;
  logic            irq_d, fiq_d, irq_q, fiq_q;

  for (genvar e = 0; e < NEVT; e++) begin : g_evt
    assign fiq_route[e] = evt[e] & fiq_en[e];
    assign irq_route[e] = evt[e] & irq_en[e] & ~fiq_en[e];
  end

  always_comb begin
    irq_d = |irq_route;
    fiq_d = |fiq_route;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      fiq_q <= fiq_d;
    end
  end

  assign irq = irq_q;
  assign fiq = fiq_q;

  // R4: full FIQ enable leaves IRQ quiet
  p_fiq_override_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (&fiq_en) |=> !irq);

  // R8: no events, no requests one edge later
  p_quiet_events_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == '0) |=> (!irq && !fiq));

  // R1: zero control register keeps the core silent
  p_zero_ctrl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0 && fiq_en == '0) |=> (!irq && !fiq));
endmodule

// File: rtl/tsteer_top.sv
module tsteer_top #(
  parameter int NCORE  = tsteer_pkg::NCORE,
  parameter int NEVT   = tsteer_pkg::NEVT,
  parameter int ADDR_W = tsteer_pkg::ADDR_W,
  parameter int DATA_W = tsteer_pkg::DATA_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bus_valid_i,
  input  logic                    bus_write_i,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic [DATA_W-1:0]       bus_wdata_i,
  output logic [DATA_W-1:0]       bus_rdata_o,
  input  logic [NCORE*NEVT-1:0]   evt_i,
  output logic [NCORE-1:0]        irq_o,
  output logic [NCORE-1:0]        fiq_o
);
  localparam int CW = 2 * NEVT;

  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic [NCORE*CW-1:0] ctrl_flat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  tsteer_regbank #(
    .NCORE(NCORE), .NEVT(NEVT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) regs_i (
    .clk       (clk_i),
    .rst_n     (rst_n),
    .bus_valid (bus_valid_i),
    .bus_write (bus_write_i),
    .bus_addr  (bus_addr_i),
    .bus_wdata (bus_wdata_i),
    .bus_rdata (bus_rdata_o),
    .ctrl_flat (ctrl_flat)
  );

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    tsteer_core_mux #(.NEVT(NEVT)) mux_i (
      .clk    (clk_i),
      .rst_n  (rst_n),
      .evt    (evt_i[c*NEVT +: NEVT]),
      .irq_en (ctrl_flat[c*CW +: NEVT]),
      .fiq_en (ctrl_flat[c*CW + NEVT +: NEVT]),
      .irq    (irq_o[c]),
      .fiq    (fiq_o[c])
    );
  end
endmodule

// File: tb/tsteer_tb.sv
module tsteer_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] evt = '0;
  logic [3:0]  irq, fiq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tsteer_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .evt_i(evt), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [1:0] model(input logic [7:0] ctl, input logic [3:0] ev);
    logic i, f;
    i = 1'b0; f = 1'b0;
    for (int e = 0; e < 4; e++) begin
      if (ev[e] && ctl[4+e]) f = 1'b1;
      else if (ev[e] && ctl[e]) i = 1'b1;
    end
    return {f, i};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [3:0]  ei, ef;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    evt = 16'hFFFF;
    @(negedge clk);
    check("R1 irq", {28'd0, irq}, 32'd0);
    check("R1 fiq", {28'd0, fiq}, 32'd0);
    for (int c = 0; c < 4; c++) begin
      rd(8'h40 + 8'(4*c), r);
      check("R1 reg", r, 32'd0);
    end

    // R5: stray offsets write nothing
    wr(8'h3C, 32'hFF); wr(8'h50, 32'hFF); wr(8'h41, 32'hFF);
    wr(8'h00, 32'hFF); wr(8'h4E, 32'hFF);
    @(negedge clk);
    check("R5 irq", {28'd0, irq}, 32'd0);
    check("R5 fiq", {28'd0, fiq}, 32'd0);
    for (int c = 0; c < 4; c++) begin
      rd(8'h40 + 8'(4*c), r);
      check("R5 reg", r, 32'd0);
    end

    // R6/R7: reserved bits and readback per core
    for (int c = 0; c < 4; c++) begin
      wr(8'h40 + 8'(4*c), 32'hFFFF_FF00 | 32'(8'h11 * (c + 1)));
    end
    for (int c = 0; c < 4; c++) begin
      rd(8'h40 + 8'(4*c), r);
      check("R6/R7 read", r, 32'(8'h11 * (c + 1)));
    end
    // R7: data holds with no further read
    repeat (3) @(negedge clk);
    check("R7 hold", bus_rdata, 32'h44);
    for (int c = 0; c < 4; c++) wr(8'h40 + 8'(4*c), 32'h0);

    // R8: one-edge latency and level following
    evt = 16'h0000;
    wr(8'h40, 32'h01);
    @(negedge clk);
    evt = 16'h0001;
    #1 check("R8 not early", {31'd0, irq[0]}, 32'd0);
    @(negedge clk);
    check("R8 rise", {31'd0, irq[0]}, 32'd1);
    evt = 16'h0000;
    #1 check("R8 hold old", {31'd0, irq[0]}, 32'd1);
    @(negedge clk);
    check("R8 fall", {31'd0, irq[0]}, 32'd0);
    evt = 16'h0001;
    @(negedge clk);
    wr(8'h40, 32'h10);
    @(negedge clk);
    check("R8/R4 enable swap irq", {31'd0, irq[0]}, 32'd0);
    check("R8/R4 enable swap fiq", {31'd0, fiq[0]}, 32'd1);
    wr(8'h40, 32'h0);

    // R2/R3/R4/R9: exhaustive sweep per core, other cores' events all high
    for (int c = 0; c < 4; c++) begin
      for (int v = 0; v < 256; v++) begin
        wr(8'h40 + 8'(4*c), 32'(v));
        for (int p = 0; p < 16; p++) begin
          logic [1:0] m;
          evt = 16'hFFFF;
          evt[4*c +: 4] = 4'(p);
          @(negedge clk);
          m = model(8'(v), 4'(p));
          ei = '0; ef = '0;
          ei[c] = m[0]; ef[c] = m[1];
          check("R2/R4/R9 irq", {28'd0, irq}, {28'd0, ei});
          check("R3/R9 fiq", {28'd0, fiq}, {28'd0, ef});
        end
      end
      wr(8'h40 + 8'(4*c), 32'h0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule